// File: doc/BRIEF.md
# CAN Bus Idle and Status Tracker

This block follows a CAN controller through its bus-level life: the wait for a quiet bus after reset, idle, receiving, transmitting, and the long recovery after bus-off. It combines that state with transmit, receive and error flags into one read-only 32-bit status word. The sampled bus level (1 = recessive) comes in with a one-cycle bit-time strobe. The rest of the controller supplies single-cycle event pulses and two level inputs (receive buffer full and error warning).

Rejoining the bus needs one run of 11 recessive bits after reset. After bus-off it needs 128 such runs, and counting begins only once the bus-off condition is cleared. While the controller waits to rejoin, the receive-status and transmit-status bits both read 1. A CPU reads the word through a registered read port at byte offset 0x08.

Top module: `can_status_tracker`

## Requirements
- R1: A read with `rd_en` high returns, one clock later on `rd_data`, the status word when `rd_addr` is 0x08 and zero at any other address. Bits 31..8 of the word are always 0. Bits 7..0 are: 7 bus-off, 6 error warning, 5 transmitting, 4 receiving, 3 transmission complete, 2 transmit buffer free, 1 data overrun, 0 receive buffer full.
- R2: After reset the status word reads 0x0000003C.
- R3: Bits 5:4 encode the activity: 00 = idle, 01 = receiving, 11 = transmitting or waiting to rejoin the bus.
- R4: After reset the block leaves the wait state only after 11 consecutive strobed recessive bits. A dominant bit before the 11th recessive bit keeps it waiting.
- R5: A bus-off entry pulse sets bit 7 and holds bits 5:4 at 11. Start events are ignored in that condition. Bus-free counting starts with the bus-off clear pulse, and the block becomes idle exactly when the 128th bus-free run completes.
- R6: The recessive run length advances only on strobed bits. A dominant bit resets it to 0, and each completed run of 11 restarts it from 0, so a partial run never counts.
- R7: In idle, a receive start enters receiving and a transmit start enters transmitting; transmit wins when both arrive together. A frame end or error pulse returns receiving or transmitting to idle without any bus-free wait.
- R8: Data overrun sets when a message-complete pulse arrives with the buffer-full input high and no error pulse in the same cycle. An error-aborted message never sets it. It stays set until a clear-overrun pulse, and a set in the same cycle as a clear wins.
- R9: Bit 0 follows the receive-buffer-full input and bit 6 follows the error-warning input, each one clock later.
- R10: An accepted transmit start clears bits 3 and 2. A transmit completion pulse sets bit 3, and a transmit buffer release pulse sets bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_strobe | input | 1 | One-cycle pulse per bit time |
| bus_bit | input | 1 | Sampled bus level, 1 = recessive |
| rx_start | input | 1 | Receive start pulse |
| tx_start | input | 1 | Transmit start pulse |
| frame_end | input | 1 | Frame end pulse |
| frame_error | input | 1 | Frame error pulse |
| busoff_enter | input | 1 | Bus-off entry pulse |
| busoff_clear | input | 1 | Bus-off clear pulse, starts recovery counting |
| msg_done | input | 1 | Whole message received pulse |
| rxbuf_full | input | 1 | Receive buffer full level |
| tx_release | input | 1 | Transmit buffer release pulse |
| tx_done | input | 1 | Transmission complete pulse |
| ovr_clear | input | 1 | Clear-overrun command pulse |
| err_warn | input | 1 | Error-warning level |
| rd_en | input | 1 | CPU read strobe |
| rd_addr | input | 8 | CPU byte address |
| rd_data | output | 32 | Registered read data |

## Verification
Two cases land in one cycle. In the first, a completed message with a full buffer arrives together with an error pulse; the error must win, and the bench expects overrun clear. In the second, a completed message with a full buffer arrives together with a clear-overrun command; the set must win, and the bench expects overrun to read 1. A third same-cycle case drives receive start and transmit start together and expects the transmitting encoding with both transmit flags cleared. Each outcome is judged by reading the status word at offset 0x08 right after the colliding pulses.

// File: rtl/can_stat_pkg.sv
package can_stat_pkg;
    typedef enum logic [2:0] {
        ST_BOOT     = 3'd0,
        ST_IDLE     = 3'd1,
        ST_RX       = 3'd2,
        ST_TX       = 3'd3,
        ST_BO_HOLD  = 3'd4,
        ST_BO_RECOV = 3'd5
    } trk_state_e;

    localparam int STAT_W = 32;

    typedef struct packed {
        logic bus_off;
        logic err_warn;
        logic txing;
        logic rxing;
        logic tx_cmpl;
        logic tx_free;
        logic overrun;
        logic rx_full;
    } stat_byte_t;
endpackage

// File: rtl/can_busfree_counter.sv
module can_busfree_counter #(
    parameter int RUN_LEN = 11,
    parameter int SEQ_NUM = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_strobe,
    input  logic bus_bit,
    input  logic restart,
    input  logic seq_en,
    output logic run_done,
    output logic seq_final
);
    localparam int RUN_W = $clog2(RUN_LEN + 1);
    localparam int SEQ_W = $clog2(SEQ_NUM);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);
    localparam logic [SEQ_W-1:0] SEQ_LAST = SEQ_W'(SEQ_NUM - 1);

    typedef struct packed {
        logic [RUN_W-1:0] run;
        logic [SEQ_W-1:0] seq;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d     = cnt_q;
        run_done  = 1'b0;
        seq_final = 1'b0;
        if (restart) begin
            cnt_d = '0;
        end else if (bit_strobe) begin
            if (!bus_bit) begin
                cnt_d.run = '0;
            end else if (cnt_q.run == RUN_LAST) begin
                run_done  = 1'b1;
                cnt_d.run = '0;
                if (seq_en) begin
                    seq_final = (cnt_q.seq == SEQ_LAST);
                    cnt_d.seq = cnt_q.seq + 1'b1;
                end
            end else begin
                cnt_d.run = cnt_q.run + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_run_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q.run <= RUN_LAST);
    assert_dominant_resets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_strobe && !bus_bit) |=> (cnt_q.run == '0));
    assert_no_strobe_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_strobe && !restart) |=> $stable(cnt_q.run));
    assert_seq_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_en && !restart) |=> $stable(cnt_q.seq));
endmodule

// File: rtl/can_state_ctrl.sv
module can_state_ctrl
    import can_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_done,
    input  logic seq_final,
    input  logic rx_start,
    input  logic tx_start,
    input  logic frame_end,
    input  logic frame_error,
    input  logic busoff_enter,
    input  logic busoff_clear,
    output logic restart,
    output logic seq_en,
    output logic tx_accept,
    output logic st_bus_off,
    output logic st_rxing,
    output logic st_txing
);
    trk_state_e state_d, state_q;

    always_comb begin
        state_d   = state_q;
        tx_accept = 1'b0;
        case (state_q)
            ST_BOOT:     if (run_done) state_d = ST_IDLE;
            ST_IDLE: begin
                if (tx_start) begin
                    state_d   = ST_TX;
                    tx_accept = !busoff_enter;
                end else if (rx_start) begin
                    state_d = ST_RX;
                end
            end
            ST_RX, ST_TX: if (frame_end || frame_error) state_d = ST_IDLE;
            ST_BO_HOLD:  if (busoff_clear) state_d = ST_BO_RECOV;
            ST_BO_RECOV: if (seq_final) state_d = ST_IDLE;
            default:     state_d = ST_BOOT;
        endcase
        if (busoff_enter) state_d = ST_BO_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    always_comb begin
        restart    = !(state_q == ST_BOOT || state_q == ST_BO_RECOV);
        seq_en     = (state_q == ST_BO_RECOV);
        st_bus_off = (state_q == ST_BO_HOLD) || (state_q == ST_BO_RECOV);
        st_rxing   = (state_q != ST_IDLE);
        st_txing   = (state_q != ST_IDLE) && (state_q != ST_RX);
    end

    assert_busoff_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busoff_enter |=> (state_q == ST_BO_HOLD));
    assert_hold_until_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BO_HOLD && !busoff_clear && !busoff_enter) |=> (state_q == ST_BO_HOLD));
    assert_recov_until_final_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BO_RECOV && !seq_final && !busoff_enter) |=> (state_q == ST_BO_RECOV));
    assert_boot_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BOOT && !run_done && !busoff_enter) |=> (state_q == ST_BOOT));
    assert_tx_priority_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && tx_start && !busoff_enter) |=> (state_q == ST_TX));
endmodule

// File: rtl/can_flag_regs.sv
module can_flag_regs
    import can_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_accept,
    input  logic tx_release,
    input  logic tx_done,
    input  logic msg_done,
    input  logic frame_error,
    input  logic rxbuf_full,
    input  logic ovr_clear,
    input  logic err_warn,
    output logic fl_tx_cmpl,
    output logic fl_tx_free,
    output logic fl_overrun,
    output logic fl_rx_full,
    output logic fl_err_warn
);
    typedef struct packed {
        logic tx_cmpl;
        logic tx_free;
        logic overrun;
        logic rx_full;
        logic err_warn;
    } flag_t;

    flag_t flag_d, flag_q;
    logic  ovr_set;

    always_comb begin
        flag_d          = flag_q;
        ovr_set         = msg_done && rxbuf_full && !frame_error;
        if (tx_accept) begin
            flag_d.tx_cmpl = 1'b0;
            flag_d.tx_free = 1'b0;
        end
        if (tx_done)    flag_d.tx_cmpl = 1'b1;
        if (tx_release) flag_d.tx_free = 1'b1;
        if (ovr_clear)  flag_d.overrun = 1'b0;
        if (ovr_set)    flag_d.overrun = 1'b1;
        flag_d.rx_full  = rxbuf_full;
        flag_d.err_warn = err_warn;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '{tx_cmpl: 1'b1, tx_free: 1'b1, default: 1'b0};
        else        flag_q <= flag_d;
    end

    assign fl_tx_cmpl  = flag_q.tx_cmpl;
    assign fl_tx_free  = flag_q.tx_free;
    assign fl_overrun  = flag_q.overrun;
    assign fl_rx_full  = flag_q.rx_full;
    assign fl_err_warn = flag_q.err_warn;

    assert_abort_no_ovr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_overrun && (!msg_done || frame_error)) |=> !fl_overrun);
    assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_overrun && !ovr_clear) |=> fl_overrun);
    assert_ovr_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_done && rxbuf_full && !frame_error && ovr_clear) |=> fl_overrun);
    assert_tx_start_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_accept && !tx_done) |=> !fl_tx_cmpl);
endmodule

// File: rtl/can_status_tracker.sv
module can_status_tracker
    import can_stat_pkg::*;
#(
    parameter int         RUN_LEN    = 11,
    parameter int         SEQ_NUM    = 128,
    parameter int         ADDR_W     = 8,
    parameter logic [7:0] STATUS_OFS = 8'h08
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_strobe,
    input  logic                bus_bit,
    input  logic                rx_start,
    input  logic                tx_start,
    input  logic                frame_end,
    input  logic                frame_error,
    input  logic                busoff_enter,
    input  logic                busoff_clear,
    input  logic                msg_done,
    input  logic                rxbuf_full,
    input  logic                tx_release,
    input  logic                tx_done,
    input  logic                ovr_clear,
    input  logic                err_warn,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [STAT_W-1:0]   rd_data
);
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(STATUS_OFS);

    logic run_done, seq_final, restart, seq_en, tx_accept;
    logic st_bus_off, st_rxing, st_txing;
    logic fl_tx_cmpl, fl_tx_free, fl_overrun, fl_rx_full, fl_err_warn;
    stat_byte_t stat_byte;
    logic [STAT_W-1:0] rd_d, rd_q;

    can_busfree_counter #(.RUN_LEN(RUN_LEN), .SEQ_NUM(SEQ_NUM)) u_cnt (
        .clk(clk), .rst_n(rst_n), .bit_strobe(bit_strobe), .bus_bit(bus_bit),
        .restart(restart), .seq_en(seq_en), .run_done(run_done), .seq_final(seq_final)
    );

    can_state_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .run_done(run_done), .seq_final(seq_final),
        .rx_start(rx_start), .tx_start(tx_start), .frame_end(frame_end),
        .frame_error(frame_error), .busoff_enter(busoff_enter), .busoff_clear(busoff_clear),
        .restart(restart), .seq_en(seq_en), .tx_accept(tx_accept),
        .st_bus_off(st_bus_off), .st_rxing(st_rxing), .st_txing(st_txing)
    );

    can_flag_regs u_flags (
        .clk(clk), .rst_n(rst_n), .tx_accept(tx_accept), .tx_release(tx_release),
        .tx_done(tx_done), .msg_done(msg_done), .frame_error(frame_error),
        .rxbuf_full(rxbuf_full), .ovr_clear(ovr_clear), .err_warn(err_warn),
        .fl_tx_cmpl(fl_tx_cmpl), .fl_tx_free(fl_tx_free), .fl_overrun(fl_overrun),
        .fl_rx_full(fl_rx_full), .fl_err_warn(fl_err_warn)
    );

    always_comb begin
        stat_byte = '{bus_off: st_bus_off, err_warn: fl_err_warn, txing: st_txing,
                      rxing: st_rxing, tx_cmpl: fl_tx_cmpl, tx_free: fl_tx_free,
                      overrun: fl_overrun, rx_full: fl_rx_full};
        rd_d = rd_q;
        if (rd_en) begin
            rd_d = (rd_addr == OFS) ? {{(STAT_W-8){1'b0}}, stat_byte} : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q;

    assert_foreign_addr_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr != OFS) |=> (rd_data == '0));
    assert_busoff_both_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == OFS && st_bus_off) |=> (rd_data[5:4] == 2'b11));
endmodule

// File: tb/can_status_tracker_bench.sv
`timescale 1ns/1ps
module can_status_tracker_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_strobe = 0, bus_bit = 1;
    logic rx_start = 0, tx_start = 0, frame_end = 0, frame_error = 0;
    logic busoff_enter = 0, busoff_clear = 0, msg_done = 0, rxbuf_full = 0;
    logic tx_release = 0, tx_done = 0, ovr_clear = 0, err_warn = 0;
    logic rd_en = 0;
    logic [7:0] rd_addr = 8'h08;
    logic [31:0] rd_data;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] got;

    always #10 clk = ~clk;

    can_status_tracker u_can_status_tracker (
        .clk(clk), .rst_n(rst_n), .bit_strobe(bit_strobe), .bus_bit(bus_bit),
        .rx_start(rx_start), .tx_start(tx_start), .frame_end(frame_end),
        .frame_error(frame_error), .busoff_enter(busoff_enter), .busoff_clear(busoff_clear),
        .msg_done(msg_done), .rxbuf_full(rxbuf_full), .tx_release(tx_release),
        .tx_done(tx_done), .ovr_clear(ovr_clear), .err_warn(err_warn),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // event bits, msb first: rx_start tx_start frame_end frame_error msg_done
    // rxbuf_full tx_release tx_done ovr_clear err_warn ; then expected status byte
    localparam logic [17:0] VEC [13] = '{
        {10'b1000000000, 8'h1C},  // R7 receive start
        {10'b0010000000, 8'h0C},  // R7 frame end
        {10'b0100000000, 8'h30},  // R10 R3 transmit start
        {10'b0000001000, 8'h34},  // R10 buffer release
        {10'b0010000100, 8'h0C},  // R10 done + end
        {10'b0000010000, 8'h0D},  // R9 buffer full
        {10'b1000010000, 8'h1D},  // R3 receiving
        {10'b0010110000, 8'h0F},  // R8 overrun
        {10'b0000000010, 8'h0C},  // R8 clear
        {10'b0000000001, 8'h4C},  // R9 warning
        {10'b1100000000, 8'h30},  // R7 tx priority
        {10'b0001000000, 8'h00},  // R7 error to idle
        {10'b0000001100, 8'h0C}   // R10 release + done
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic read_at(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); rd_en = 1'b1; rd_addr = a;
        @(negedge clk); rd_en = 1'b0; rd_addr = 8'h08;
        d = rd_data;
    endtask

    task automatic apply_ev(input logic [9:0] ev);
        @(negedge clk);
        {rx_start, tx_start, frame_end, frame_error, msg_done, rxbuf_full,
         tx_release, tx_done, ovr_clear, err_warn} = ev;
        @(negedge clk);
        {rx_start, tx_start, frame_end, frame_error, msg_done,
         tx_release, tx_done, ovr_clear} = '0;
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); bus_bit = b; bit_strobe = 1'b1;
        @(negedge clk); bit_strobe = 1'b0; bus_bit = 1'b1;
    endtask

    task automatic send_run(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b1);
    endtask

    task automatic pulse_bo(input logic ent, input logic clr);
        @(negedge clk); busoff_enter = ent; busoff_clear = clr;
        @(negedge clk); busoff_enter = 1'b0; busoff_clear = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        read_at(8'h08, got); check("R2 reset value", got, 32'h0000003C);
        read_at(8'h04, got); check("R1 other address", got, 32'h0);

        send_run(10); send_bit(1'b0);
        read_at(8'h08, got); check("R4 ten then dominant", got, 32'h3C);
        send_run(11);
        read_at(8'h08, got); check("R4 eleven recessive", got, 32'h0C);

        for (int k = 0; k < 13; k++) begin
            apply_ev(VEC[k][17:8]);
            read_at(8'h08, got);
            check($sformatf("R3/R7-R10 vector %0d", k), got, {24'h0, VEC[k][7:0]});
        end

        // error-aborted message with buffer full
        apply_ev(10'b1000010000);
        apply_ev(10'b0001010000);
        read_at(8'h08, got); check("R8 error abort", got, 32'h0D);
        apply_ev(10'b0001110000);
        read_at(8'h08, got); check("R8 done with error", got, 32'h0D);
        apply_ev(10'b0000110010);
        read_at(8'h08, got); check("R8 set beats clear", got, 32'h0F);
        apply_ev(10'b0000000010);
        read_at(8'h08, got); check("R8 clear", got, 32'h0C);

        // bus-off recovery
        pulse_bo(1'b1, 1'b0);
        read_at(8'h08, got); check("R5 bus-off entry", got, 32'hBC);
        apply_ev(10'b1100000000);
        read_at(8'h08, got); check("R5 start ignored", got, 32'hBC);
        send_run(11);
        read_at(8'h08, got); check("R5 no count before clear", got, 32'hBC);
        pulse_bo(1'b0, 1'b1);
        send_run(10); send_bit(1'b0);
        send_run(5); send_bit(1'b0);
        for (int s = 0; s < 127; s++) send_run(11);
        read_at(8'h08, got); check("R6 127 runs plus partials", got, 32'hBC);
        send_run(11);
        read_at(8'h08, got); check("R5 128th run idle", got, 32'h0C);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule